// File: doc/BRIEF.md
# Register-Access Serial Master for a 24-Bit Three-Wire Control Port

This block lets on-chip logic program an external bridge device whose control port takes 24-bit frames on a chip-select, a serial clock, a data-out line and an optional data-in line. A requester hands over one register access at a time: an 8-bit register number, a 16-bit value and a write/read flag. Each access becomes two frames, each with its own chip-select window. The first frame selects the register. The second frame either writes the value or fetches the register's contents.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole two-frame access, so the requester must hold its request fields stable until the handshake completes. There is no queue. The completion side has no back-pressure: `done` pulses for one cycle and `rdata` is valid only in that cycle.

The serial timing is set in system clock cycles by two parameters. `HALF_DIV` is the length of each clock phase. `GUARD_DIV` is the chip-select guard time, sized so that it can cover 16 cycles of the slave's own clock. The `HAS_MISO` parameter removes the data-in path for boards that leave that line unconnected.

Top module: `spi24_reg_master`

## Requirements
- R1: Out of reset, `spi_cs_n`, `spi_clk` and `spi_mosi` are high, `req_ready` is high and `done` is low.
- R2: Every chip-select low window holds exactly 24 rising clock edges. Data is shifted most significant bit first.
- R3: A write to register N with value V sends frame 0x70_00_NN, then frame 0x72_VVVV, each in its own chip-select window.
- R4: A read from register N sends frame 0x70_00_NN, then frame 0x73_0000. `rdata` is the last 16 bits sampled from `spi_miso` during the second frame, first-sampled bit most significant.
- R5: `spi_clk` is high whenever `spi_cs_n` is high. While chip-select is low, `spi_mosi` changes only while `spi_clk` is low. `spi_miso` is sampled at the end of each low phase, just before the rising edge.
- R6: `spi_cs_n` falls exactly `GUARD_DIV` cycles before the first falling clock edge. It rises `HALF_DIV`+`GUARD_DIV` cycles after the final rising edge. It then stays high at least `GUARD_DIV` cycles before the next fall.
- R7: `req_ready` is high only while no access is in progress. After a handshake it drops in the next cycle. A request held valid while `req_ready` is low causes no frames and is taken only once `req_ready` returns.
- R8: `done` is a one-cycle pulse at the end of each access's second frame, one per accepted request. `rdata` is 0 for a write.
- R9: With `HAS_MISO`=0, reads still complete and return 0 whatever level `spi_miso` holds. Writes are unaffected.
- R10: Inside a frame, each low clock phase and each high clock phase between bits lasts exactly `HALF_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_reg | input | 8 | Register number |
| req_wdata | input | 16 | Value to write |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid with `done` |
| spi_cs_n | output | 1 | Active-low chip-select |
| spi_clk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave (ignored when `HAS_MISO`=0) |

## Verification
The in-RTL properties watch, on every cycle, the invariants that need no reference value:
- the idle-high clock while deselected;
- data-out stable during high phases;
- 24 rising edges per window;
- the single-cycle `done`;
- `req_ready` implying a quiet bus;
- the drop of `req_ready` after a handshake.

Frame contents, read data, the exact phase and guard lengths, ignoring of held requests during back-pressure, and the `HAS_MISO`=0 variant need expected values. Only the bench's scenarios show those: it uses a modelled slave register file and compares against a scoreboard.

// File: rtl/spi24_pkg.sv
package spi24_pkg;
  localparam int FRAME_BITS = 24;
  localparam int REG_W      = 8;
  localparam int VAL_W      = 16;
  localparam int BIT_IW     = $clog2(FRAME_BITS);

  localparam logic [7:0] PFX_SELECT = 8'h70;
  localparam logic [7:0] PFX_WRITE  = 8'h72;
  localparam logic [7:0] PFX_READ   = 8'h73;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LEAD, PH_LOW, PH_HIGH, PH_TAIL, PH_GAP
  } phase_t;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_SELECT, SQ_DATA
  } seq_t;
endpackage

// File: rtl/spi24_phase_timer.sv
module spi24_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/spi24_frame_engine.sv
module spi24_frame_engine
  import spi24_pkg::*;
#(
  parameter int HALF_DIV  = 13,
  parameter int GUARD_DIV = 50,
  parameter bit HAS_MISO  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] word,
  output logic                  fin,
  output logic [VAL_W-1:0]      rx_low,
  output logic                  cs_n,
  output logic                  sclk,
  output logic                  mosi,
  input  logic                  miso
);
  localparam int LONGEST = (HALF_DIV > GUARD_DIV) ? HALF_DIV : GUARD_DIV;
  localparam int CW      = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] HALF_LEN  = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] GUARD_LEN = CW'(GUARD_DIV - 1);

  phase_t ph, ph_nxt;
  logic   expired, step, last_bit, miso_eff;
  logic [CW-1:0]         len_nxt;
  logic [FRAME_BITS-1:0] tx_sh;
  logic [VAL_W-1:0]      rx_sh;
  logic [BIT_IW-1:0]     bit_idx;

  generate
    if (HAS_MISO) begin : g_miso
      assign miso_eff = miso;
    end else begin : g_no_miso
      assign miso_eff = 1'b0;
    end
  endgenerate

  assign last_bit = (bit_idx == BIT_IW'(FRAME_BITS - 1));

  always_comb begin
    ph_nxt = ph;
    unique case (ph)
      PH_IDLE: if (start)   ph_nxt = PH_LEAD;
      PH_LEAD: if (expired) ph_nxt = PH_LOW;
      PH_LOW:  if (expired) ph_nxt = PH_HIGH;
      PH_HIGH: if (expired) ph_nxt = last_bit ? PH_TAIL : PH_LOW;
      PH_TAIL: if (expired) ph_nxt = PH_GAP;
      PH_GAP:  if (expired) ph_nxt = PH_IDLE;
      default:              ph_nxt = PH_IDLE;
    endcase
  end

  assign step = (ph_nxt != ph);

  always_comb begin
    unique case (ph_nxt)
      PH_LOW, PH_HIGH:          len_nxt = HALF_LEN;
      PH_LEAD, PH_TAIL, PH_GAP: len_nxt = GUARD_LEN;
      default:                  len_nxt = '0;
    endcase
  end

  spi24_phase_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (step),
    .len     (len_nxt),
    .expired (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      tx_sh   <= '0;
      rx_sh   <= '0;
      bit_idx <= '0;
    end else begin
      ph <= ph_nxt;
      if (ph == PH_IDLE && start) begin
        tx_sh   <= word;
        bit_idx <= '0;
      end
      if (ph == PH_LOW && expired)
        rx_sh <= {rx_sh[VAL_W-2:0], miso_eff};
      if (ph == PH_HIGH && expired && !last_bit) begin
        tx_sh   <= {tx_sh[FRAME_BITS-2:0], 1'b0};
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  assign fin    = (ph == PH_GAP) && expired;
  assign rx_low = rx_sh;
  assign cs_n   = (ph == PH_IDLE) || (ph == PH_GAP);
  assign sclk   = (ph != PH_LOW);
  assign mosi   = (ph inside {PH_LOW, PH_HIGH, PH_TAIL}) ? tx_sh[FRAME_BITS-1] : 1'b1;

  // checker state: rising clock edges seen in the current select window
  logic [BIT_IW:0] rise_cnt;
  logic            sclk_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt <= '0;
      sclk_q   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      if (cs_n)                rise_cnt <= '0;
      else if (sclk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  assert_clk_parks_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  assert_mosi_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk) && !cs_n && !$past(cs_n)) |-> $stable(mosi));
  assert_frame_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rise_cnt == (BIT_IW+1)'(FRAME_BITS)));
endmodule

// File: rtl/spi24_sequencer.sv
module spi24_sequencer
  import spi24_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [REG_W-1:0]      req_reg,
  input  logic [VAL_W-1:0]      req_wdata,
  output logic                  done,
  output logic [VAL_W-1:0]      rdata,
  output logic                  frame_start,
  output logic [FRAME_BITS-1:0] frame_word,
  input  logic                  frame_fin,
  input  logic [VAL_W-1:0]      frame_rx
);
  seq_t             st;
  logic             is_read;
  logic [VAL_W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= SQ_IDLE;
      is_read     <= 1'b0;
      val_q       <= '0;
      frame_start <= 1'b0;
      frame_word  <= '0;
      done        <= 1'b0;
      rdata       <= '0;
    end else begin
      frame_start <= 1'b0;
      done        <= 1'b0;
      unique case (st)
        SQ_IDLE: if (req_valid) begin
          is_read     <= !req_write;
          val_q       <= req_wdata;
          frame_word  <= {PFX_SELECT, {(VAL_W-REG_W){1'b0}}, req_reg};
          frame_start <= 1'b1;
          st          <= SQ_SELECT;
        end
        SQ_SELECT: if (frame_fin) begin
          frame_word  <= is_read ? {PFX_READ, {VAL_W{1'b0}}} : {PFX_WRITE, val_q};
          frame_start <= 1'b1;
          st          <= SQ_DATA;
        end
        SQ_DATA: if (frame_fin) begin
          done  <= 1'b1;
          rdata <= is_read ? frame_rx : '0;
          st    <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign req_ready = (st == SQ_IDLE);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_accept_drops_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/spi24_reg_master.sv
module spi24_reg_master
  import spi24_pkg::*;
#(
  parameter int HALF_DIV  = 13,
  parameter int GUARD_DIV = 50,
  parameter bit HAS_MISO  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        done,
  output logic [15:0] rdata,
  output logic        spi_cs_n,
  output logic        spi_clk,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic                  f_start, f_fin;
  logic [FRAME_BITS-1:0] f_word;
  logic [VAL_W-1:0]      f_rx;

  spi24_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_reg     (req_reg),
    .req_wdata   (req_wdata),
    .done        (done),
    .rdata       (rdata),
    .frame_start (f_start),
    .frame_word  (f_word),
    .frame_fin   (f_fin),
    .frame_rx    (f_rx)
  );

  spi24_frame_engine #(
    .HALF_DIV  (HALF_DIV),
    .GUARD_DIV (GUARD_DIV),
    .HAS_MISO  (HAS_MISO)
  ) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (f_start),
    .word   (f_word),
    .fin    (f_fin),
    .rx_low (f_rx),
    .cs_n   (spi_cs_n),
    .sclk   (spi_clk),
    .mosi   (spi_mosi),
    .miso   (spi_miso)
  );

  assert_ready_bus_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> spi_cs_n);
  assert_start_on_idle_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    f_start |-> spi_cs_n);
endmodule

// File: tb/spi24_reg_master_test.sv
module spi24_reg_master_test;
  localparam int HALF  = 3;
  localparam int GUARD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, done, cs_n, sclk, mosi;
  logic miso = 1'b0;
  logic [15:0] rdata;

  spi24_reg_master #(.HALF_DIV(HALF), .GUARD_DIV(GUARD), .HAS_MISO(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_reg(req_reg), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .spi_cs_n(cs_n), .spi_clk(sclk),
    .spi_mosi(mosi), .spi_miso(miso));

  // variant without the data-in path, tightest timing
  logic v2_valid = 1'b0, v2_write = 1'b0;
  logic [7:0] v2_reg = '0;
  logic [15:0] v2_wdata = '0;
  logic v2_ready, v2_done, v2_cs_n, v2_sclk, v2_mosi;
  logic [15:0] v2_rdata;

  spi24_reg_master #(.HALF_DIV(1), .GUARD_DIV(1), .HAS_MISO(1'b0)) uut2 (
    .clk(clk), .rst_n(rst_n), .req_valid(v2_valid), .req_ready(v2_ready),
    .req_write(v2_write), .req_reg(v2_reg), .req_wdata(v2_wdata),
    .done(v2_done), .rdata(v2_rdata), .spi_cs_n(v2_cs_n), .spi_clk(v2_sclk),
    .spi_mosi(v2_mosi), .spi_miso(1'b1));

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] seed_val(input logic [7:0] a);
    return 16'hA500 ^ {a, ~a};
  endfunction

  // scoreboard queues
  logic [24:0] exp_frames[$];  // {is_read, word}
  logic [16:0] exp_res[$];     // {is_read, value}
  logic [15:0] model_mem[256];
  int n_issued = 0, n_done = 0;

  task automatic issue(input bit wr, input logic [7:0] rg, input logic [15:0] val);
    exp_frames.push_back({!wr, 8'h70, 8'h00, rg});
    exp_frames.push_back(wr ? {1'b0, 8'h72, val} : {1'b1, 8'h73, 16'h0000});
    exp_res.push_back(wr ? {1'b0, 16'h0000} : {1'b1, model_mem[rg]});
    if (wr) model_mem[rg] = val;
    n_issued++;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_reg = rg; req_wdata = val;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // slave model and bus monitor
  logic [15:0] slave_mem[256];
  logic [7:0]  slave_sel = '0;
  logic [23:0] resp = '0, shin = '0;
  logic pcs = 1'b1, psclk = 1'b1, pmosi = 1'b1, pdone = 1'b0;
  int lead = 0, run = 0, nrise = 0, gap = 0;
  bit first = 1'b0, seen = 1'b0, frame_err = 1'b0, ready_err = 1'b0, done_err = 1'b0;

  initial for (int i = 0; i < 256; i++) begin
    model_mem[i] = seed_val(8'(i));
    slave_mem[i] = seed_val(8'(i));
  end

  always @(negedge clk) if (rst_n) begin
    if (cs_n && !sclk) frame_err = 1'b1;                                        // R5
    if (sclk && psclk && !cs_n && !pcs && mosi !== pmosi) frame_err = 1'b1;     // R5
    if (req_ready && !cs_n) ready_err = 1'b1;                                   // R7
    if (done && pdone) done_err = 1'b1;                                         // R8
    if (pcs && !cs_n) begin
      if (seen) chk(gap >= GUARD, "R6 deselect gap", gap, GUARD);
      lead = 1; run = 0; nrise = 0; first = 1'b1; shin = '0; frame_err = 1'b0;
      resp = {8'h00, slave_mem[slave_sel]};
    end else if (!cs_n) begin
      if (!sclk && psclk) begin
        if (first) begin
          chk(lead == GUARD, "R6 lead guard", lead, GUARD);
          first = 1'b0;
        end else if (run != HALF) frame_err = 1'b1;                             // R10 high phase
        miso = resp[23 - nrise];
        run = 1;
      end else if (sclk && !psclk) begin
        if (run != HALF) frame_err = 1'b1;                                      // R10 low phase
        shin = {shin[22:0], mosi};
        nrise++;
        run = 1;
      end else begin
        run++;
        if (first) lead++;
      end
    end else if (!pcs && cs_n) begin
      chk(nrise == 24, "R2 rising edges per frame", nrise, 24);
      chk(run == HALF + GUARD, "R6 tail guard", run, HALF + GUARD);
      chk(!frame_err, "R5/R10 phase timing", frame_err, 0);
      if (exp_frames.size() == 0) chk(1'b0, "R7 unexpected frame", shin, 0);
      else begin
        logic [24:0] e;
        e = exp_frames.pop_front();
        chk(shin == e[23:0], e[24] ? "R4 read frame" : "R3 write frame", shin, e[23:0]);
      end
      if (shin[23:16] == 8'h70) slave_sel = shin[7:0];
      if (shin[23:16] == 8'h72) slave_mem[slave_sel] = shin[15:0];
      miso = 1'b0;
      gap = 1; seen = 1'b1;
    end else gap++;
    if (done) begin
      n_done++;
      if (exp_res.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
      else begin
        logic [16:0] r;
        r = exp_res.pop_front();
        chk(rdata == r[15:0], r[16] ? "R4 read data" : "R8 write rdata zero", rdata, r[15:0]);
      end
    end
    pcs = cs_n; psclk = sclk; pmosi = mosi; pdone = done;
  end

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({cs_n, sclk, mosi} == 3'b111, "R1 bus idle levels", {cs_n, sclk, mosi}, 3'b111);
    chk(req_ready == 1'b1 && done == 1'b0, "R1 ready/done", {req_ready, done}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cs_n, sclk, mosi, req_ready} == 4'hF, "R1 after release", {cs_n, sclk, mosi, req_ready}, 4'hF);

    issue(1'b0, 8'h10, 16'h0);        // R4 read of untouched register
    issue(1'b1, 8'hB7, 16'h0301);     // R3
    issue(1'b1, 8'h00, 16'hFFFF);     // R3 all ones
    issue(1'b1, 8'hFF, 16'h0000);     // R3 all zeros
    issue(1'b0, 8'hB7, 16'h0);        // R4
    issue(1'b0, 8'h00, 16'h0);
    issue(1'b0, 8'hFF, 16'h0);
    // R7: back-to-back issues hold valid through back-pressure
    issue(1'b1, 8'h55, 16'h8001);
    issue(1'b0, 8'h55, 16'h0);
    issue(1'b1, 8'hAA, 16'h7FFE);
    issue(1'b0, 8'hAA, 16'h0);
    while (exp_res.size() != 0 || !req_ready) @(negedge clk);
    repeat (GUARD + 4) @(negedge clk);
    chk(exp_frames.size() == 0, "R3 all frames seen", exp_frames.size(), 0);
    chk(n_done == n_issued, "R7 one done per accepted request", n_done, n_issued);
    chk(!ready_err, "R7 ready only when bus idle", ready_err, 0);
    chk(!done_err, "R8 done single cycle", done_err, 0);

    // R9: no data-in path, miso tied high
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      v2_valid = 1'b1; v2_write = (k == 0); v2_reg = 8'h33; v2_wdata = 16'hBEEF;
      while (!v2_ready) @(negedge clk);
      @(posedge clk);
      #1 v2_valid = 1'b0;
      begin
        int w = 0;
        while (!v2_done && w < 2000) begin @(negedge clk); w++; end
        chk(v2_done, "R9 access completes", v2_done, 1);
        chk(v2_rdata == 16'h0000, "R9 rdata zero", v2_rdata, 0);
      end
    end
    finished = 1'b1;
    summary();
  end
endmodule